// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block produces the bit-rate clock enables for one channel of a serial controller. It takes two external clock pins, a recovered-clock input and the system clock. It turns each of them into a one-cycle tick in the system clock domain. A reloadable down-counting baud generator can run from either the system clock or the first clock pin.

The transmitter and the receiver each pick their own tick source: first pin, second pin, generator or recovered clock. Each source is then divided by a rate multiplier of 1, 16, 32 or 64. The result comes out as single-cycle clock enables, ready for a shifter that runs on the system clock.

The second clock pin can also be turned around as an output. It then carries one of four levels: the first pin's level (crystal), a transmit clock level, the generator output or the recovered clock. Each time the generator count reaches zero, a status flag is set, and an interrupt request follows if it is enabled. Software sets everything up through a small byte-wide register file. Reads are combinational, so the read data follows the read address in the same cycle.

Top module: `baud_clk_unit`

## Requirements
- R1: After reset every register reads 0, and `tx_clk_en`, `rx_clk_en`, `pin_b_oe` and `zero_irq` are all low.
- R2: With generator control (address 4) bit0=1 and bit1=1, the generator runs from the system clock. Its output rises once every 2*(TC+2) cycles, where TC is {address 3, address 2}. Route source code 2 passes this rise to the clock enables.
- R3: Mode register (address 0) bits[1:0] set the divider: code 0 divides by 1, code 1 by 16, code 2 by 32 and code 3 by 64. The clock enables pulse once per that many source ticks.
- R4: Route register (address 1) bits[1:0] choose the transmit source. Code 0 is a rising edge of `pin_a_i`, 1 a rising edge of `pin_b_i`, 2 a generator rise and 3 a rising edge of `rec_clk_i`.
- R5: Route bits[3:2] choose the receive source with the same codes as R4, independently of the transmit source.
- R6: With generator bit1=0, the generator counts rising edges of `pin_a_i`, and its period is 2*(TC+2) such edges.
- R7: Addresses 2 and 3 read back the written time-constant bytes. A new time constant first applies at the next generator reload and leaves the half period in progress untouched.
- R8: With generator bit0=0, the generator output is low and produces no ticks.
- R9: Each generator zero count sets status bit0 (address 5), and writing 1 to that bit clears it. `zero_irq` is high while the flag is set and generator bit2 is 1.
- R10: Route bit6 drives `pin_b_oe`. Route bits[5:4] pick the level on `pin_b_o`: 0 the `pin_a_i` level, 1 a level that toggles on every `tx_clk_en`, 2 the generator output, 3 the `rec_clk_i` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 1 | First external clock pin |
| pin_b_i | input | 1 | Second external clock pin, input side |
| rec_clk_i | input | 1 | Recovered clock from the clock recovery logic |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tx_clk_en | output | 1 | Transmit bit-clock enable pulse |
| rx_clk_en | output | 1 | Receive bit-clock enable pulse |
| pin_b_o | output | 1 | Level driven on the second clock pin |
| pin_b_oe | output | 1 | Output enable for the second clock pin |
| zero_irq | output | 1 | Generator zero-count interrupt request |

## Verification
Several rules hold on every cycle, and the assertions check them there:
- A disabled generator holds its output low.
- The generator output only changes on a zero count.
- A divide-by-1 source tick always yields an enable.
- Every enable is caused by a source tick.
- A zero count always sets the status flag.

Other behaviour only shows up over many cycles, so the bench scenarios carry it: the exact enable intervals for every source and divider combination, the independent receive routing, the generator period from pin edges, the one-reload delay of a new time constant, and the pin-output level selection.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int TC_W   = 2 * DATA_W;

  typedef enum logic [1:0] {
    SRC_PIN_A = 2'd0,
    SRC_PIN_B = 2'd1,
    SRC_GEN   = 2'd2,
    SRC_REC   = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    PO_XTAL  = 2'd0,
    PO_TXLVL = 2'd1,
    PO_GEN   = 2'd2,
    PO_REC   = 2'd3
  } pin_out_e;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd1;
  localparam logic [ADDR_W-1:0] A_TCLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TCHI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_GEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

  typedef struct packed {
    logic     po_en;
    pin_out_e po_sel;
    clk_src_e rx_src;
    clk_src_e tx_src;
  } route_t;

  typedef struct packed {
    logic zint_en;
    logic use_sys;
    logic gen_en;
  } genctl_t;

endpackage

// File: rtl/bcu_pin_sync.sv
module bcu_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/bcu_baud_gen.sv
module bcu_baud_gen #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic            in_tick,
  input  logic [TC_W-1:0] tc,
  output logic            gen_q,
  output logic            gen_tick,
  output logic            zero_hit
);

  localparam int CNT_W = TC_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             prev_q;

  assign zero_hit = gen_en && in_tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!gen_en) begin
      cnt_d = {1'b0, tc};
      out_d = 1'b0;
    end else if (in_tick) begin
      if (cnt_q == '0) begin
        cnt_d = {1'b0, tc} + CNT_W'(1);
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      prev_q <= out_q;
    end
  end

  assign gen_q    = out_q;
  assign gen_tick = out_q & ~prev_q;

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !gen_q);

  assert_toggle_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && !$stable(gen_q)) |-> $past(zero_hit));

endmodule

// File: rtl/bcu_rate_div.sv
module bcu_rate_div #(
  parameter int MAX_LOG = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mult_code,
  input  logic       src_tick,
  output logic       pulse
);

  logic [MAX_LOG-1:0] cnt_q, cnt_d;
  logic [MAX_LOG-1:0] lim_m1;
  logic               pulse_q, pulse_d;

  always_comb begin
    case (mult_code)
      2'd0:    lim_m1 = MAX_LOG'(0);
      2'd1:    lim_m1 = MAX_LOG'(15);
      2'd2:    lim_m1 = MAX_LOG'(31);
      default: lim_m1 = MAX_LOG'(63);
    endcase
  end

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (src_tick) begin
      if (cnt_q >= lim_m1) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + MAX_LOG'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  assert_x1_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_code == 2'd0 && src_tick) |=> pulse);

  assert_pulse_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(src_tick));

endmodule

// File: rtl/bcu_regs.sv
module bcu_regs
  import bcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              zero_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        mult_code,
  output route_t            route,
  output genctl_t           genctl,
  output logic [TC_W-1:0]   tc,
  output logic              zero_flag
);

  logic [1:0]        mode_q, mode_d;
  route_t            route_q, route_d;
  genctl_t           gen_q, gen_d;
  logic [DATA_W-1:0] tclo_q, tclo_d, tchi_q, tchi_d;
  logic              flag_q, flag_d;

  always_comb begin
    mode_d  = mode_q;
    route_d = route_q;
    gen_d   = gen_q;
    tclo_d  = tclo_q;
    tchi_d  = tchi_q;
    flag_d  = flag_q;
    if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_d  = wr_data[1:0];
        A_ROUTE: route_d = route_t'(wr_data[6:0]);
        A_TCLO:  tclo_d  = wr_data;
        A_TCHI:  tchi_d  = wr_data;
        A_GEN:   gen_d   = genctl_t'(wr_data[2:0]);
        A_STAT:  if (wr_data[0]) flag_d = 1'b0;
        default: ;
      endcase
    end
    if (zero_hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      route_q <= '0;
      gen_q   <= '0;
      tclo_q  <= '0;
      tchi_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      route_q <= route_d;
      gen_q   <= gen_d;
      tclo_q  <= tclo_d;
      tchi_q  <= tchi_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {6'b0, mode_q};
      A_ROUTE: rd_data = {1'b0, route_q};
      A_TCLO:  rd_data = tclo_q;
      A_TCHI:  rd_data = tchi_q;
      A_GEN:   rd_data = {5'b0, gen_q};
      A_STAT:  rd_data = {7'b0, flag_q};
      default: rd_data = '0;
    endcase
  end

  assign mult_code = mode_q;
  assign route     = route_q;
  assign genctl    = gen_q;
  assign tc        = {tchi_q, tclo_q};
  assign zero_flag = flag_q;

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> zero_flag);

endmodule

// File: rtl/baud_clk_unit.sv
module baud_clk_unit
  import bcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_LOG     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              rec_clk_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_clk_en,
  output logic              rx_clk_en,
  output logic              pin_b_o,
  output logic              pin_b_oe,
  output logic              zero_irq
);

  localparam int N_IN  = 3;
  localparam int N_DIR = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // input synchronisers and rising-edge ticks: 0 pin A, 1 pin B, 2 recovered
  logic [N_IN-1:0] raw_in, lvl, lvl_prev_q, rise;
  assign raw_in = {rec_clk_i, pin_b_i, pin_a_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    bcu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .async_i(raw_in[i]),
      .sync_o (lvl[i])
    );
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) lvl_prev_q <= '0;
    else             lvl_prev_q <= lvl;
  end
  assign rise = lvl & ~lvl_prev_q;

  // register file
  logic [1:0]      mult_code;
  route_t          route;
  genctl_t         genctl;
  logic [TC_W-1:0] tc;
  logic            zero_flag;
  logic            zero_hit;

  bcu_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .zero_hit (zero_hit),
    .rd_data  (rd_data),
    .mult_code(mult_code),
    .route    (route),
    .genctl   (genctl),
    .tc       (tc),
    .zero_flag(zero_flag)
  );

  // baud generator
  logic gen_in_tick, gen_lvl, gen_tick;
  assign gen_in_tick = genctl.use_sys ? 1'b1 : rise[0];

  bcu_baud_gen #(.TC_W(TC_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .gen_en  (genctl.gen_en),
    .in_tick (gen_in_tick),
    .tc      (tc),
    .gen_q   (gen_lvl),
    .gen_tick(gen_tick),
    .zero_hit(zero_hit)
  );

  // per-direction source selection and rate division: 0 transmit, 1 receive
  clk_src_e         dir_src [N_DIR];
  logic [N_DIR-1:0] dir_tick, dir_en;
  assign dir_src[0] = route.tx_src;
  assign dir_src[1] = route.rx_src;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    always_comb begin
      case (dir_src[d])
        SRC_PIN_A: dir_tick[d] = rise[0];
        SRC_PIN_B: dir_tick[d] = rise[1];
        SRC_GEN:   dir_tick[d] = gen_tick;
        default:   dir_tick[d] = rise[2];
      endcase
    end

    bcu_rate_div #(.MAX_LOG(MAX_LOG)) u_div (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .mult_code(mult_code),
      .src_tick (dir_tick[d]),
      .pulse    (dir_en[d])
    );
  end

  assign tx_clk_en = dir_en[0];
  assign rx_clk_en = dir_en[1];

  // transmit clock level for the pin output
  logic tx_lvl_q, tx_lvl_d;
  always_comb begin
    tx_lvl_d = tx_lvl_q;
    if (dir_en[0]) tx_lvl_d = ~tx_lvl_q;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tx_lvl_q <= 1'b0;
    else             tx_lvl_q <= tx_lvl_d;
  end

  // second pin output
  logic po_lvl;
  always_comb begin
    case (route.po_sel)
      PO_XTAL:  po_lvl = lvl[0];
      PO_TXLVL: po_lvl = tx_lvl_q;
      PO_GEN:   po_lvl = gen_lvl;
      default:  po_lvl = lvl[2];
    endcase
  end

  assign pin_b_oe = route.po_en;
  assign pin_b_o  = route.po_en & po_lvl;
  assign zero_irq = zero_flag & genctl.zint_en;

endmodule

// File: tb/baud_clk_unit_tb_top.sv
`timescale 1ns/1ps
module baud_clk_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_a_i = 1'b0, pin_b_i = 1'b0, rec_clk_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_clk_en, rx_clk_en, pin_b_o, pin_b_oe, zero_irq;

  int total = 0, bad = 0, cyc = 0;
  int pa_half = 3, pb_half = 4, rc_half = 5;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_clk_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .rec_clk_i(rec_clk_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_clk_en(tx_clk_en),
    .rx_clk_en(rx_clk_en), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe),
    .zero_irq(zero_irq)
  );

  initial forever begin repeat (pa_half) @(negedge clk); pin_a_i = ~pin_a_i; end
  initial forever begin repeat (pb_half) @(negedge clk); pin_b_i = ~pin_b_i; end
  initial forever begin repeat (rc_half) @(negedge clk); rec_clk_i = ~rec_clk_i; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [7:0] route(input int tx, input int rx, input int po, input int en);
    return {1'b0, en[0], po[1:0], rx[1:0], tx[1:0]};
  endfunction

  function automatic int mult(input int code);
    case (code)
      0: return 1;
      1: return 16;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  // source period in system clock cycles; generator taken from the system clock
  function automatic int base(input int src, input int tc);
    case (src)
      0: return 2 * pa_half;
      1: return 2 * pb_half;
      2: return 2 * (tc + 2);
      default: return 2 * rc_half;
    endcase
  endfunction

  function automatic bit sig(input int k);
    case (k)
      0: return tx_clk_en;
      1: return rx_clk_en;
      default: return pin_b_o;
    endcase
  endfunction

  // interval between the 3rd and 4th rising edges of a signal
  task automatic measure(input int k, output int iv);
    bit prev = sig(k);
    int rises = 0, t3 = 0, guard = 0;
    iv = -1;
    while (rises < 4 && guard < 30000) begin
      @(negedge clk); guard++;
      if (sig(k) && !prev) begin
        rises++;
        if (rises == 3) t3 = cyc;
        if (rises == 4) iv = cyc - t3;
      end
      prev = sig(k);
    end
  endtask

  task automatic set_tc(input int tc);
    wr(3'd2, tc[7:0]);
    wr(3'd3, tc[15:8]);
  endtask

  initial begin
    logic [7:0] d;
    int iv, tc, md, ts, rs, t0;
    bit seen;
    void'($urandom(32'h1234_abcd));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk(d == 8'h00, "R1 register reset", d, 0);
    end
    chk(!tx_clk_en && !rx_clk_en && !pin_b_oe && !zero_irq, "R1 outputs low",
        {tx_clk_en, rx_clk_en, pin_b_oe, zero_irq}, 0);

    // R7 readback
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C);
    rd(3'd2, d); chk(d == 8'hA5, "R7 tc low readback", d, 8'hA5);
    rd(3'd3, d); chk(d == 8'h3C, "R7 tc high readback", d, 8'h3C);

    // R2 generator from system clock, x1, transmit from generator
    set_tc(3);
    wr(3'd0, 8'd0);
    wr(3'd1, route(2, 0, 0, 0));
    wr(3'd4, 8'h03);
    measure(0, iv); chk(iv == 10, "R2 gen period tc=3", iv, 10);
    set_tc(0);
    measure(0, iv); chk(iv == 4, "R2 gen period tc=0", iv, 4);

    // R5 receive independent of transmit
    wr(3'd1, route(2, 3, 0, 0));
    measure(0, iv); chk(iv == 4, "R5 tx stays on generator", iv, 4);
    measure(1, iv); chk(iv == 2 * rc_half, "R5 rx from recovered", iv, 2 * rc_half);

    // R4 transmit from pin B
    wr(3'd1, route(1, 0, 0, 0));
    measure(0, iv); chk(iv == 2 * pb_half, "R4 tx from pin B", iv, 2 * pb_half);
    measure(1, iv); chk(iv == 2 * pa_half, "R5 rx from pin A", iv, 2 * pa_half);

    // R6 generator from pin A edges
    set_tc(1);
    wr(3'd4, 8'h01);
    wr(3'd1, route(2, 2, 0, 0));
    measure(0, iv); chk(iv == 6 * 2 * pa_half, "R6 gen from pin A", iv, 6 * 2 * pa_half);

    // R7 new time constant waits for next reload
    set_tc(20);
    wr(3'd4, 8'h03);
    measure(0, iv); chk(iv == 44, "R7 tc=20 period", iv, 44);
    seen = 0;
    while (!seen) begin @(negedge clk); seen = tx_clk_en; end
    t0 = cyc;
    wr(3'd2, 8'd2);
    seen = 0;
    while (!seen) begin @(negedge clk); seen = tx_clk_en; end
    chk(cyc - t0 == 26, "R7 change at next reload", cyc - t0, 26);
    measure(0, iv); chk(iv == 8, "R7 new tc period", iv, 8);

    // R3 dividers, directed
    for (int m = 0; m < 4; m++) begin
      wr(3'd0, m[7:0]);
      measure(0, iv);
      chk(iv == 8 * mult(m), "R3 divider code", iv, 8 * mult(m));
    end

    // R3/R4/R5 random mix, generator from system clock
    for (int n = 0; n < 10; n++) begin
      tc = $urandom_range(0, 5);
      md = $urandom_range(0, 3);
      ts = $urandom_range(0, 3);
      rs = $urandom_range(0, 3);
      set_tc(tc);
      wr(3'd0, md[7:0]);
      wr(3'd1, route(ts, rs, 0, 0));
      measure(0, iv);
      chk(iv == base(ts, tc) * mult(md), "R4 random tx", iv, base(ts, tc) * mult(md));
      measure(1, iv);
      chk(iv == base(rs, tc) * mult(md), "R5 random rx", iv, base(rs, tc) * mult(md));
    end

    // R10 pin output selection
    wr(3'd0, 8'd0);
    set_tc(3);
    wr(3'd1, route(0, 0, 0, 0));
    chk(pin_b_oe == 1'b0, "R10 oe off", pin_b_oe, 0);
    wr(3'd1, route(0, 0, 0, 1));
    chk(pin_b_oe == 1'b1, "R10 oe on", pin_b_oe, 1);
    measure(2, iv); chk(iv == 2 * pa_half, "R10 crystal level", iv, 2 * pa_half);
    wr(3'd1, route(0, 0, 1, 1));
    measure(2, iv); chk(iv == 4 * pa_half, "R10 tx clock level", iv, 4 * pa_half);
    wr(3'd1, route(0, 0, 2, 1));
    measure(2, iv); chk(iv == 10, "R10 generator level", iv, 10);
    wr(3'd1, route(0, 0, 3, 1));
    measure(2, iv); chk(iv == 2 * rc_half, "R10 recovered level", iv, 2 * rc_half);

    // R9 zero flag and interrupt
    rd(3'd5, d); chk(d[0] == 1'b1, "R9 flag set", d[0], 1);
    chk(zero_irq == 1'b0, "R9 irq masked", zero_irq, 0);
    wr(3'd4, 8'h07);
    chk(zero_irq == 1'b1, "R9 irq raised", zero_irq, 1);
    wr(3'd4, 8'h04);
    wr(3'd5, 8'h01);
    rd(3'd5, d); chk(d[0] == 1'b0, "R9 flag cleared", d[0], 0);
    chk(zero_irq == 1'b0, "R9 irq dropped", zero_irq, 0);

    // R8 disabled generator: no ticks, output low, flag stays clear
    wr(3'd1, route(2, 2, 2, 1));
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (tx_clk_en || rx_clk_en || pin_b_o) seen = 1;
    end
    chk(!seen, "R8 no activity when disabled", seen, 0);
    rd(3'd5, d); chk(d[0] == 1'b0, "R8 no zero count", d[0], 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule